// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a single-port synchronous static RAM. It lets a bus controller mix reads and writes on consecutive clock cycles without idle cycles when the direction changes. Every control input is sampled on the rising clock edge. Read data leaves through an output register. Write data is taken two active cycles after its address. As a result, a write's data and a read's data use the bus in the same relative cycle, and the two directions never collide.

A cycle starts in one of two ways. With the advance input low, a new operation is loaded: a read, a write or a deselect. With advance high, the operation loaded last is repeated at the next address of a four-beat burst. Burst addresses step through the low two address bits, in linear or interleaved order. Each byte lane has its own write enable. Three chip enables of mixed polarity select the device, so several devices can share one address space. Driving the clock enable input high freezes the whole pipeline.

Top module: `nwsram`

## Requirements
- R1: The device is selected at a load edge only when `selN0` is low, `sel1` is high and `selN2` is low. A load edge with any other combination is a deselect cycle: it drives nothing onto the bus and changes no stored word, whatever `wrN` is.
- R2: With every edge enabled, a read loaded at edge k places the addressed word on `dataOut` with `dataDrive` high from just after edge k+1 until edge k+2.
- R3: For a write loaded at edge k, the word is taken from `dataIn` at edge k+2, which is the second enabled edge after the load, and is stored at the write's address.
- R4: `byteWrN` is active low and is sampled together with the address. Bit i low writes lane i (`dataIn[8i+7:8i]`). Lanes whose bit is high keep their old contents.
- R5: Reads and writes can alternate on every cycle with no idle cycles. A read loaded on the cycle right after a write to the same address returns the newly written lanes merged with the old ones.
- R6: At an edge with `advance` high, the operation loaded last (read, write or deselect) repeats at the next burst address. The chip enables, `wrN` and `addr` are ignored on that edge.
- R7: A burst keeps the upper address bits of its load address and steps the low two bits. Beat n (n = 1, 2, 3, then wrapping back to 0) uses start+n mod 4 when `interleave` is low, and start XOR n when `interleave` is high.
- R8: An edge with `clkEnN` high is ignored: no word is written, and `dataOut`, `dataDrive` and all pipeline state keep their values.
- R9: `outEnN` is active low and acts without a clock edge. While it is high, `dataDrive` is low.
- R10: After reset, the pipeline holds no operation and `dataDrive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset of the pipeline state |
| clkEnN | input | 1 | Active-low clock enable; high suspends the block |
| selN0 | input | 1 | Chip enable, active low |
| sel1 | input | 1 | Chip enable, active high |
| selN2 | input | 1 | Chip enable, active low |
| wrN | input | 1 | Operation select at a load edge: low write, high read |
| advance | input | 1 | High continues the burst, low loads a new operation |
| interleave | input | 1 | Burst order: low linear, high interleaved |
| byteWrN | input | BYTES | Active-low per-lane write enables |
| addr | input | ADDR_W | Word address |
| outEnN | input | 1 | Asynchronous active-low output enable |
| dataIn | input | BYTES*BYTE_W | Write data from the bus |
| dataOut | output | BYTES*BYTE_W | Read data to the bus |
| dataDrive | output | 1 | Bus drive enable for dataOut |

## Verification
The assertions check on every cycle how the control pipeline relates to the pins. A selected read load must raise the fetch strobe one edge later. A write load must reach the commit strobe after the next enabled edge. A deselect load must never fetch. A burst continuation keeps the operation it inherits. A suspended edge leaves the output and the strobes unchanged. The bus drive must never be high while the output enable is high. Only the bench's scenarios can show that the right data arrives: stored words, per-lane merging, forwarding from a write into the read that follows it, the exact addresses of both burst orders across every start address, and the fact that deselected cycles and garbage on the write data bus during suspended cycles leave memory untouched.

// File: rtl/nwsram_pkg.sv
package nwsram_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } opKind;

  // Strobes from control to datapath for the current cycle.
  typedef struct packed {
    logic step;    // edge is enabled
    logic fetch;   // stage A holds a read: load the output register
    logic commit;  // stage B holds a write: store dataIn
  } ctlStrobes;

endpackage

// File: rtl/nwsram_burst.sv
module nwsram_burst #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              step,
  input  logic              load,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] effAddr
);
  localparam int HiW = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseAddr;
  logic [BURST_W-1:0] beat;
  logic [BURST_W-1:0] nextBeat;
  logic [BURST_W-1:0] lowBits;

  assign nextBeat = beat + BURST_W'(1);
  assign lowBits  = interleave ? (baseAddr[BURST_W-1:0] ^ nextBeat)
                               : (baseAddr[BURST_W-1:0] + nextBeat);
  assign effAddr  = load ? addrIn : {baseAddr[ADDR_W-1 -: HiW], lowBits};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr <= '0;
      beat     <= '0;
    end else if (step) begin
      if (load) begin
        baseAddr <= addrIn;
        beat     <= '0;
      end else begin
        beat     <= nextBeat;
      end
    end
  end
endmodule

// File: rtl/nwsram_ctrl.sv
module nwsram_ctrl
  import nwsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEnN,
  input  logic              selN0,
  input  logic              sel1,
  input  logic              selN2,
  input  logic              wrN,
  input  logic              advance,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] issueAddr,
  output ctlStrobes         stb
);
  logic  selected;
  opKind loadOp;
  opKind issueOp;
  opKind aOp;   // operation sampled at the previous enabled edge
  opKind bOp;   // operation sampled two enabled edges ago

  assign selected = !selN0 && sel1 && !selN2;

  always_comb begin
    if (!selected)  loadOp = OP_NONE;
    else if (wrN)   loadOp = OP_READ;
    else            loadOp = OP_WRITE;
  end

  // A continuation repeats whatever was issued last, which is stage A.
  assign issueOp = advance ? aOp : loadOp;

  nwsram_burst #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_burst (
    .clk       (clk),
    .rstN      (rstN),
    .step      (!clkEnN),
    .load      (!advance),
    .interleave(interleave),
    .addrIn    (addr),
    .effAddr   (issueAddr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOp <= OP_NONE;
      bOp <= OP_NONE;
    end else if (!clkEnN) begin
      aOp <= issueOp;
      bOp <= aOp;
    end
  end

  assign stb.step   = !clkEnN;
  assign stb.fetch  = (aOp == OP_READ);
  assign stb.commit = (bOp == OP_WRITE);
endmodule

// File: rtl/nwsram_datapath.sv
module nwsram_datapath
  import nwsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8,
  localparam int DataW = BYTES * BYTE_W,
  localparam int Depth = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes         stb,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [BYTES-1:0]  byteWrN,
  input  logic [DataW-1:0]  dataIn,
  output logic [DataW-1:0]  dataOut,
  output logic              dataValid
);
  logic [ADDR_W-1:0] aAddr;
  logic [ADDR_W-1:0] bAddr;
  logic [BYTES-1:0]  aByteN;
  logic [BYTES-1:0]  bByteN;
  logic [DataW-1:0]  fetchWord;
  logic              sameWord;

  // A write committing at this edge to the word being fetched forwards its lanes.
  assign sameWord = stb.commit && (bAddr == aAddr);

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] laneMem [Depth];
    logic              laneWr;

    assign laneWr = stb.step && stb.commit && !bByteN[b];

    always_ff @(posedge clk) begin
      if (laneWr) laneMem[bAddr] <= dataIn[b*BYTE_W +: BYTE_W];
    end

    assign fetchWord[b*BYTE_W +: BYTE_W] =
      (sameWord && !bByteN[b]) ? dataIn[b*BYTE_W +: BYTE_W] : laneMem[aAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aAddr     <= '0;
      bAddr     <= '0;
      aByteN    <= '1;
      bByteN    <= '1;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else if (stb.step) begin
      aAddr     <= issueAddr;
      aByteN    <= byteWrN;
      bAddr     <= aAddr;
      bByteN    <= aByteN;
      dataValid <= stb.fetch;
      if (stb.fetch) dataOut <= fetchWord;
    end
  end
endmodule

// File: rtl/nwsram.sv
module nwsram
  import nwsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BYTES   = 2,
  parameter int BYTE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clkEnN,
  input  logic                    selN0,
  input  logic                    sel1,
  input  logic                    selN2,
  input  logic                    wrN,
  input  logic                    advance,
  input  logic                    interleave,
  input  logic [BYTES-1:0]        byteWrN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    outEnN,
  input  logic [BYTES*BYTE_W-1:0] dataIn,
  output logic [BYTES*BYTE_W-1:0] dataOut,
  output logic                    dataDrive
);
  ctlStrobes         ctlStb;
  logic [ADDR_W-1:0] issueAddr;
  logic              dataValid;

  nwsram_ctrl #(
    .ADDR_W (ADDR_W),
    .BURST_W(BURST_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEnN    (clkEnN),
    .selN0     (selN0),
    .sel1      (sel1),
    .selN2     (selN2),
    .wrN       (wrN),
    .advance   (advance),
    .interleave(interleave),
    .addr      (addr),
    .issueAddr (issueAddr),
    .stb       (ctlStb)
  );

  nwsram_datapath #(
    .ADDR_W(ADDR_W),
    .BYTES (BYTES),
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (ctlStb),
    .issueAddr(issueAddr),
    .byteWrN  (byteWrN),
    .dataIn   (dataIn),
    .dataOut  (dataOut),
    .dataValid(dataValid)
  );

  assign dataDrive = dataValid && !outEnN;
endmodule

// File: rtl/nwsram_checker.sv
module nwsram_checker
  import nwsram_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEnN,
  input logic              selN0,
  input logic              sel1,
  input logic              selN2,
  input logic              wrN,
  input logic              advance,
  input logic              outEnN,
  input logic              dataDrive,
  input logic [DATA_W-1:0] dataOut,
  input ctlStrobes         stb
);
  logic pinSel;
  assign pinSel = !selN0 && sel1 && !selN2;

  // R9: no drive while the output enable is high
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    dataDrive |-> !outEnN);

  // R8: a suspended edge changes neither output data nor strobes
  p_hold_state_r8: assert property (@(posedge clk) disable iff (!rstN)
    clkEnN |=> ($stable(dataOut) && $stable(stb.fetch) && $stable(stb.commit)));

  // R1: a deselect load never leads to a fetch
  p_deselect_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && !pinSel) |=> !stb.fetch);

  // R2: a selected read load reaches the fetch stage one edge later
  p_read_issue_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && pinSel && wrN) |=> stb.fetch);

  // R3: a write load commits after the next enabled edge
  p_write_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && !advance && pinSel && !wrN) ##1 !clkEnN |=> stb.commit);

  // R6: a continuation keeps the operation kind in stage A
  p_burst_keeps_op_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEnN && advance) |=> $stable(stb.fetch));
endmodule

bind nwsram nwsram_checker #(.DATA_W(BYTES*BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEnN   (clkEnN),
  .selN0    (selN0),
  .sel1     (sel1),
  .selN2    (selN2),
  .wrN      (wrN),
  .advance  (advance),
  .outEnN   (outEnN),
  .dataDrive(dataDrive),
  .dataOut  (dataOut),
  .stb      (ctlStb)
);

// File: tb/nwsram_test.sv
`timescale 1ns/1ps
module nwsram_test;
  localparam int AW = 4;
  localparam int NB = 2;
  localparam int DW = 16;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clkEnN = 1'b0;
  logic          selN0 = 1'b1, sel1 = 1'b1, selN2 = 1'b0;
  logic          wrN = 1'b1, advance = 1'b0, interleave = 1'b0;
  logic [NB-1:0] byteWrN = '1;
  logic [AW-1:0] addr = '0;
  logic          outEnN = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataDrive;

  always #5 clk = ~clk;

  nwsram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(8), .BURST_W(2)) uut (
    .clk(clk), .rstN(rstN), .clkEnN(clkEnN), .selN0(selN0), .sel1(sel1),
    .selN2(selN2), .wrN(wrN), .advance(advance), .interleave(interleave),
    .byteWrN(byteWrN), .addr(addr), .outEnN(outEnN), .dataIn(dataIn),
    .dataOut(dataOut), .dataDrive(dataDrive)
  );

  typedef struct {
    int            op;   // 0 none, 1 read, 2 write
    logic [AW-1:0] a;
    logic [NB-1:0] bn;
  } slotT;

  logic [DW-1:0] model [NW];
  slotT          h1, h2;
  int            lastOp = 0;
  logic [AW-1:0] bBase = '0;
  logic [1:0]    bBeat = '0;
  logic [DW-1:0] pat = 16'h1357;
  int            nTests = 0, nFail = 0;
  bit            done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] nextPat();
    pat = pat * 16'd25173 + 16'd13849;
    return pat;
  endfunction

  // One enabled cycle. The bus slot of this cycle belongs to the op issued two edges ago.
  task automatic cyc(input bit s0N, input bit s1, input bit s2N, input bit wN,
                     input bit adv, input bit mode, input logic [NB-1:0] bn,
                     input logic [AW-1:0] a, input bit oeN, input string req);
    slotT          cur;
    logic [DW-1:0] wd;
    outEnN = oeN;
    wd = nextPat();
    dataIn = wd;
    if (h2.op == 2) begin
      for (int l = 0; l < NB; l++)
        if (!h2.bn[l]) model[h2.a][l*8 +: 8] = wd[l*8 +: 8];
    end
    #1;
    if (h2.op == 1) begin
      check(dataDrive === !oeN, req, "read drive", 32'(dataDrive), 32'(!oeN));
      if (!oeN) begin
        check(dataOut === model[h2.a], req, "read data", 32'(dataOut), 32'(model[h2.a]));
        outEnN = 1'b1; #1;
        check(dataDrive === 1'b0, "R9", "drive with oe high", 32'(dataDrive), 32'd0);
        outEnN = 1'b0; #1;
      end
    end else begin
      check(dataDrive === 1'b0, req, "idle drive", 32'(dataDrive), 32'd0);
    end
    interleave = mode;
    cur.bn = bn;
    if (adv) begin
      cur.op = lastOp;
      bBeat  = bBeat + 2'd1;
      cur.a  = {bBase[AW-1:2], mode ? (bBase[1:0] ^ bBeat) : (bBase[1:0] + bBeat)};
    end else begin
      cur.op = (!s0N && s1 && !s2N) ? (wN ? 1 : 2) : 0;
      bBase  = a;
      bBeat  = 2'd0;
      cur.a  = a;
    end
    lastOp = cur.op;
    selN0 = s0N; sel1 = s1; selN2 = s2N; wrN = wN; advance = adv;
    byteWrN = bn; addr = a; clkEnN = 1'b0;
    @(posedge clk); @(negedge clk);
    h2 = h1; h1 = cur;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bn, input string req);
    cyc(0, 1, 0, 0, 0, 0, bn, a, 0, req);
  endtask
  task automatic rd(input logic [AW-1:0] a, input string req);
    cyc(0, 1, 0, 1, 0, 0, '0, a, 0, req);
  endtask
  task automatic idle(input string req);
    cyc(1, 1, 0, 1, 0, 0, '1, '0, 0, req);
  endtask

  // R8: a suspended edge with hostile inputs must change nothing visible
  task automatic hold();
    logic [DW-1:0] o;
    logic          d;
    o = dataOut; d = dataDrive;
    clkEnN = 1'b1; selN0 = 1'b0; sel1 = 1'b1; selN2 = 1'b0; wrN = 1'b0;
    advance = 1'b0; byteWrN = '0; addr = '0; dataIn = 16'hDEAD;
    @(posedge clk); @(negedge clk);
    check(dataOut === o, "R8", "held data", 32'(dataOut), 32'(o));
    check(dataDrive === d, "R8", "held drive", 32'(dataDrive), 32'(d));
  endtask

  initial begin
    h1 = '{0, '0, '0};
    h2 = '{0, '0, '0};
    repeat (3) @(negedge clk);
    check(dataDrive === 1'b0, "R10", "drive in reset", 32'(dataDrive), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(dataDrive === 1'b0, "R10", "drive after reset", 32'(dataDrive), 32'd0);

    // R3 then R2: fill every word, read every word back
    for (int a = 0; a < NW; a++) wr(AW'(a), '0, "R3");
    idle("R3"); idle("R3");
    for (int a = 0; a < NW; a++) rd(AW'(a), "R2");
    idle("R2"); idle("R2");

    // R4 with R5: each lane mask, read straight after the write
    for (int a = 0; a < 4; a++)
      for (int m = 0; m < 4; m++) begin
        wr(AW'(a), NB'(m), "R4");
        rd(AW'(a), "R4");
      end
    idle("R4"); idle("R4");

    // R5: mixed directions on every cycle
    for (int i = 0; i < NW; i++) begin
      wr(AW'(i), '0, "R5");
      rd(AW'(i), "R5");
      rd(AW'((i + 5) % NW), "R5");
      wr(AW'((i + 3) % NW), 2'b10, "R5");
    end
    idle("R5"); idle("R5");

    // R1: every unselected enable combination, with write and read requests
    for (int c = 0; c < 8; c++) begin
      if (c != 3'b010) begin
        cyc(c[0], c[1], c[2], 0, 0, 0, '0, AW'(c), 0, "R1");
        cyc(c[0], c[1], c[2], 1, 0, 0, '0, AW'(c), 0, "R1");
      end
    end
    idle("R1"); idle("R1");
    for (int a = 0; a < 8; a++) rd(AW'(a), "R1");
    idle("R1"); idle("R1");

    // R6 and R7: bursts from every start in both orders, garbage on ignored pins
    for (int mode = 0; mode < 2; mode++)
      for (int s = 0; s < NW; s++) begin
        cyc(0, 1, 0, 0, 0, mode[0], '0, AW'(s), 0, "R7");
        for (int k = 0; k < 3; k++)
          cyc(1, 0, 1, 1, 1, mode[0], '0, AW'(s + 7 * k), 0, "R6");
        cyc(0, 1, 0, 1, 0, mode[0], '0, AW'(s), 0, "R7");
        for (int k = 0; k < 3; k++)
          cyc(1, 0, 1, 0, 1, mode[0], '1, AW'(s + 5), 0, "R6");
      end
    idle("R7"); idle("R7");

    // R6: a continued deselect stays deselected
    cyc(1, 1, 0, 0, 0, 0, '0, '0, 0, "R6");
    cyc(0, 1, 0, 0, 1, 0, '0, '0, 0, "R6");
    idle("R6"); idle("R6");
    for (int a = 0; a < 4; a++) rd(AW'(a), "R6");
    idle("R6"); idle("R6");

    // R8: suspended edges inside a mixed stream
    rd(4'd3, "R8"); hold(); rd(4'd4, "R8"); hold(); hold();
    wr(4'd5, '0, "R8"); hold(); rd(4'd5, "R8"); hold();
    idle("R8"); hold(); idle("R8"); idle("R8");
    rd(4'd0, "R8"); idle("R8"); idle("R8");

    // R9: read with the output enable held high
    rd(4'd6, "R9");
    cyc(1, 1, 0, 1, 0, 0, '1, '0, 1, "R9");
    cyc(1, 1, 0, 1, 0, 0, '1, '0, 1, "R9");

    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nTests++; nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule